// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master and the bit-phase strobes that a byte engine needs, all from the system clock. A single 32-bit divider word sets the length of the SCL low phase and the length of the SCL high phase independently. Each half is scaled by a fixed prescale factor, so the line rate is the system clock divided by the prescale times the sum of the two counts. A driver reaches a given rate by rounding its counts up, which keeps the line at or below that rate. Rates of 100 kHz and 400 kHz are the usual targets.

The block also drives the SDA line level for bus conditions and for data bits. A rising `run` opens a transaction with a START condition. At the middle of each SCL low phase the block pulses `sda_change` and samples a two-bit command from the byte engine. The command asks for another data bit (taken from `tx_bit`), a STOP, or a repeated START. At the middle of each data-bit high phase the block pulses `sda_sample`, which is where a receiver samples SDA. Dropping `run` abandons the transfer at once and releases both lines. Slave clock stretching, glitch filtering and arbitration are not part of this block.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, and whenever the block is idle, SCL and SDA are released high, `bus_free` is 1, and both strobes are 0.
- R2: An SCL low phase lasts PRESCALE*low cycles and a data-bit high phase lasts PRESCALE*high cycles. The low count is `div_cfg[15:0]` and the high count is `div_cfg[31:16]`.
- R3: A count field of 0 is treated as 1, so the phase lasts PRESCALE cycles.
- R4: `sda_change` pulses for one cycle, floor(Lcyc/2) cycles after SCL falls, where Lcyc is the low-phase length in cycles. SDA takes its new level on the following cycle, and the command is sampled in that same cycle.
- R5: `sda_sample` pulses for one cycle, floor(Hcyc/2) cycles after SCL rises in a data bit, where Hcyc is the high-phase length in cycles. SDA does not change while SCL is high in a data bit.
- R6: When idle, a rising edge of `run` pulls SDA low while SCL stays high and drops `bus_free`. SCL falls Hcyc cycles later.
- R7: Command 1 (STOP) drives SDA low in the low phase and then lets SCL rise. SDA rises Hcyc cycles after SCL rises, and at that point `bus_free` returns to 1.
- R8: Command 2 (repeated START) drives SDA high in the low phase and lets SCL rise. SDA falls Hcyc cycles later, and SCL falls after a further Hcyc cycles.
- R9: A new `div_cfg` value is used only from the next SCL falling edge, or at once while the block is idle. A change made during a bit does not alter that bit's remaining low or high time.
- R10: With `run` low, SCL and SDA are released on the next cycle. After a STOP, the block stays idle while `run` remains high and needs a new rising edge to start again.
- R11: Command 0 and command 3 both mean "data bit". SDA then follows `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Transaction enable; rising edge starts, low aborts |
| cmd | input | 2 | Next action, sampled at low-phase midpoint: 0/3 bit, 1 STOP, 2 repeated START |
| tx_bit | input | 1 | Data bit level for the next bit |
| div_cfg | input | 32 | SCL low count in [15:0], high count in [31:16] |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| bus_free | output | 1 | High while no transaction is in progress |
| sda_change | output | 1 | One-cycle strobe at the middle of the SCL low phase |
| sda_sample | output | 1 | One-cycle strobe at the middle of a data-bit high phase |

## Verification
The bench builds the block with its default parameters: 16-bit count fields and a prescale of 8. It drives small counts so that several transfers fit in a short run. Zero fields bring the clamp to one within reach. An asymmetric setting of five low to one high, and a change of divider in the middle of a bit, show whether each half is latched on its own and only at the falling edge. Command 3, repeated START, STOP with `run` held high, and an abort in the middle of a low phase cover the remaining orderings.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_LOW,
        PH_HIGH,
        PH_STOP_HI,
        PH_RS_HI
    } phase_e;

    typedef enum logic [1:0] {
        CMD_BIT     = 2'd0,
        CMD_STOP    = 2'd1,
        CMD_RESTART = 2'd2,
        CMD_BIT_ALT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        NX_DATA,
        NX_STOP,
        NX_RESTART
    } next_e;

    function automatic next_e decode_cmd(input logic [1:0] c);
        case (c)
            CMD_STOP:    return NX_STOP;
            CMD_RESTART: return NX_RESTART;
            default:     return NX_DATA;
        endcase
    endfunction

endpackage

// File: rtl/scl_div_latch.sv
module scl_div_latch #(
    parameter int DIV_W    = 16,
    parameter int PRESCALE = 8,
    parameter int LEN_W    = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [2*DIV_W-1:0] div_cfg,
    output logic [LEN_W-1:0]   low_len,
    output logic [LEN_W-1:0]   high_len
);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [DIV_W-1:0] field;
        logic [LEN_W-1:0] eff;
        logic [LEN_W-1:0] len_q;

        assign field = div_cfg[h*DIV_W +: DIV_W];
        assign eff   = (field == '0) ? LEN_W'(1) : LEN_W'(field);

        always_ff @(posedge clk) begin
            if (rst) begin
                len_q <= LEN_W'(PRESCALE);
            end else if (load) begin
                len_q <= eff * LEN_W'(PRESCALE);
            end
        end
    end

    assign low_len  = g_half[0].len_q;
    assign high_len = g_half[1].len_q;

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [1:0]       cmd,
    input  logic             tx_bit,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic             load_div,
    output logic             scl_o,
    output logic             sda_o,
    output logic             bus_free,
    output logic             chg_tick,
    output logic             smp_tick
);

    phase_e           ph;
    next_e            nx_q;
    logic [LEN_W-1:0] cnt;
    logic             sda_q;
    logic             run_d;

    logic high_end, low_end, low_mid, high_mid;

    assign high_end = (cnt == high_len - 1'b1);
    assign low_end  = (cnt == low_len - 1'b1);
    assign low_mid  = (cnt == (low_len >> 1));
    assign high_mid = (cnt == (high_len >> 1));

    assign load_div = (ph == PH_IDLE) ||
                      (run && (ph == PH_START || ph == PH_HIGH) && high_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            nx_q  <= NX_DATA;
            cnt   <= '0;
            sda_q <= 1'b1;
            run_d <= 1'b0;
        end else begin
            run_d <= run;
            cnt   <= cnt + 1'b1;
            if (!run && ph != PH_IDLE) begin
                ph    <= PH_IDLE;
                cnt   <= '0;
                sda_q <= 1'b1;
            end else begin
                case (ph)
                    PH_IDLE: begin
                        cnt   <= '0;
                        sda_q <= 1'b1;
                        if (run && !run_d) begin
                            ph    <= PH_START;
                            sda_q <= 1'b0;
                        end
                    end
                    PH_START, PH_HIGH: begin
                        if (high_end) begin
                            ph  <= PH_LOW;
                            cnt <= '0;
                        end
                    end
                    PH_LOW: begin
                        if (low_mid) begin
                            nx_q <= decode_cmd(cmd);
                            case (decode_cmd(cmd))
                                NX_STOP:    sda_q <= 1'b0;
                                NX_RESTART: sda_q <= 1'b1;
                                default:    sda_q <= tx_bit;
                            endcase
                        end
                        if (low_end) begin
                            cnt <= '0;
                            case (nx_q)
                                NX_STOP:    ph <= PH_STOP_HI;
                                NX_RESTART: ph <= PH_RS_HI;
                                default:    ph <= PH_HIGH;
                            endcase
                        end
                    end
                    PH_STOP_HI: begin
                        if (high_end) begin
                            ph    <= PH_IDLE;
                            cnt   <= '0;
                            sda_q <= 1'b1;
                        end
                    end
                    PH_RS_HI: begin
                        if (high_end) begin
                            ph    <= PH_START;
                            cnt   <= '0;
                            sda_q <= 1'b0;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    assign scl_o    = (ph != PH_LOW);
    assign sda_o    = sda_q;
    assign bus_free = (ph == PH_IDLE);
    assign chg_tick = (ph == PH_LOW) && low_mid;
    assign smp_tick = (ph == PH_HIGH) && high_mid;

    assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (scl_o && sda_o && bus_free));

    assert_sda_steady_high_R5: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HIGH && $past(ph) == PH_HIGH) |-> $stable(sda_o));

    assert_low_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LOW) |-> (cnt < low_len));

    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chg_tick, smp_tick}));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int DIV_W    = 16,
    parameter int PRESCALE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [1:0]         cmd,
    input  logic               tx_bit,
    input  logic [2*DIV_W-1:0] div_cfg,
    output logic               scl_o,
    output logic               sda_o,
    output logic               bus_free,
    output logic               sda_change,
    output logic               sda_sample
);

    localparam int LEN_W = DIV_W + $clog2(PRESCALE) + 1;

    logic             load_div;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;

    scl_div_latch #(
        .DIV_W    (DIV_W),
        .PRESCALE (PRESCALE),
        .LEN_W    (LEN_W)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (load_div),
        .div_cfg  (div_cfg),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_phase_fsm #(
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cmd      (cmd),
        .tx_bit   (tx_bit),
        .low_len  (low_len),
        .high_len (high_len),
        .load_div (load_div),
        .scl_o    (scl_o),
        .sda_o    (sda_o),
        .bus_free (bus_free),
        .chg_tick (sda_change),
        .smp_tick (sda_sample)
    );

    assert_low_len_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!scl_o && $past(!scl_o)) |-> $stable(low_len));

    assert_high_len_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (scl_o && $past(scl_o) && !bus_free && $past(!bus_free)) |-> $stable(high_len));

endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;

    localparam int EV_SCL_FALL = 0;
    localparam int EV_SCL_RISE = 1;
    localparam int EV_SDA_FALL = 2;
    localparam int EV_SDA_RISE = 3;
    localparam int EV_CHG      = 4;
    localparam int EV_SMP      = 5;

    typedef struct {
        int    cyc;
        int    kind;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        tx_bit = 1'b0;
    logic [31:0] div_cfg = 32'h0001_0001;
    logic        scl_o, sda_o, bus_free, sda_change, sda_sample;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    exp_t q[$];
    bit   mon_en = 1'b0;
    logic p_scl, p_sda;
    int   L_len = 8, H_len = 8, T = 0;
    bit   cur = 1'b1;

    scl_clock_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .cmd        (cmd),
        .tx_bit     (tx_bit),
        .div_cfg    (div_cfg),
        .scl_o      (scl_o),
        .sda_o      (sda_o),
        .bus_free   (bus_free),
        .sda_change (sda_change),
        .sda_sample (sda_sample)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv, input string what);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic push(input int c, input int k, input string r);
        exp_t e;
        e.cyc = c; e.kind = k; e.req = r;
        q.push_back(e);
    endtask

    task automatic observe(input int k);
        exp_t e;
        n_checks++;
        if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R2 unexpected event: actual kind %0d at cycle %0d expected none", k, cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
                n_fail++;
                $display("FAIL %s event: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         e.req, k, cyc, e.kind, e.cyc);
            end
        end
    endtask

    // monitor: turns output changes into events and matches them against the scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            if (scl_o !== p_scl) observe(scl_o ? EV_SCL_RISE : EV_SCL_FALL);
            if (sda_o !== p_sda) observe(sda_o ? EV_SDA_RISE : EV_SDA_FALL);
            if (sda_change) observe(EV_CHG);
            if (sda_sample) observe(EV_SMP);
            p_scl = scl_o;
            p_sda = sda_o;
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic int scaled(input int v);
        return 8 * ((v == 0) ? 1 : v);
    endfunction

    task automatic set_div(input int lo, input int hi);
        div_cfg = {hi[15:0], lo[15:0]};
        L_len = scaled(lo);
        H_len = scaled(hi);
    endtask

    task automatic start_txn(input string tag);
        int c0;
        c0 = cyc;
        run = 1'b1;
        push(c0 + 1, EV_SDA_FALL, "R6");
        cur = 1'b0;
        T = c0 + 1 + H_len;
        push(T, EV_SCL_FALL, tag);
        wait_until(c0 + 1);
        check("R6", bus_free, 0, "bus_free after start");
        check("R6", scl_o, 1, "scl held high during start");
    endtask

    task automatic data_bit(input bit b, input logic [1:0] code, input string tag,
                            input bit chg_div, input int nlo, input int nhi);
        int mid;
        mid = T + L_len / 2;
        push(mid, EV_CHG, "R4");
        if (b != cur) push(mid + 1, b ? EV_SDA_RISE : EV_SDA_FALL, (code == 2'd3) ? "R11" : "R4");
        push(T + L_len, EV_SCL_RISE, tag);
        push(T + L_len + H_len / 2, EV_SMP, "R5");
        push(T + L_len + H_len, EV_SCL_FALL, tag);
        wait_until(mid);
        cmd = code;
        tx_bit = b;
        if (chg_div) div_cfg = {nhi[15:0], nlo[15:0]};
        cur = b;
        T = T + L_len + H_len;
        if (chg_div) begin
            L_len = scaled(nlo);
            H_len = scaled(nhi);
        end
    endtask

    task automatic stop_txn();
        int mid;
        mid = T + L_len / 2;
        push(mid, EV_CHG, "R4");
        if (cur) push(mid + 1, EV_SDA_FALL, "R7");
        push(T + L_len, EV_SCL_RISE, "R7");
        push(T + L_len + H_len, EV_SDA_RISE, "R7");
        wait_until(mid);
        cmd = 2'd1;
        wait_until(T + L_len + H_len - 1);
        check("R7", sda_o, 0, "sda low before stop edge");
        check("R7", bus_free, 0, "busy before stop edge");
        wait_until(T + L_len + H_len);
        check("R7", bus_free, 1, "bus_free after stop");
        cur = 1'b1;
    endtask

    task automatic restart_txn();
        int mid;
        mid = T + L_len / 2;
        push(mid, EV_CHG, "R4");
        if (!cur) push(mid + 1, EV_SDA_RISE, "R8");
        push(T + L_len, EV_SCL_RISE, "R8");
        push(T + L_len + H_len, EV_SDA_FALL, "R8");
        push(T + L_len + 2 * H_len, EV_SCL_FALL, "R8");
        wait_until(mid);
        cmd = 2'd2;
        T = T + L_len + 2 * H_len;
        cur = 1'b0;
    endtask

    task automatic finish_up();
        n_checks++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing events: actual %0d pending expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", scl_o, 1, "scl after reset");
        check("R1", sda_o, 1, "sda after reset");
        check("R1", bus_free, 1, "bus_free after reset");
        check("R1", sda_change, 0, "change strobe after reset");
        check("R1", sda_sample, 0, "sample strobe after reset");
        p_scl = scl_o;
        p_sda = sda_o;
        mon_en = 1'b1;

        // transfer A: 16/24 cycles, data, cmd 3, repeated start, divider change, stop
        set_div(2, 3);
        repeat (2) @(negedge clk);
        start_txn("R2");
        data_bit(1'b1, 2'd0, "R2", 1'b0, 0, 0);
        data_bit(1'b0, 2'd0, "R2", 1'b0, 0, 0);
        data_bit(1'b1, 2'd3, "R11", 1'b0, 0, 0);
        data_bit(1'b1, 2'd0, "R2", 1'b0, 0, 0);
        restart_txn();
        data_bit(1'b0, 2'd0, "R9", 1'b1, 1, 1);
        data_bit(1'b1, 2'd0, "R9", 1'b0, 0, 0);
        stop_txn();
        repeat (30) @(negedge clk);
        check("R10", bus_free, 1, "no restart while run held high");
        check("R10", scl_o, 1, "scl released while idle");
        run = 1'b0;
        repeat (3) @(negedge clk);

        // transfer B: zero counts clamp to one, abort in the middle of a low phase
        set_div(0, 0);
        start_txn("R3");
        data_bit(1'b1, 2'd0, "R3", 1'b0, 0, 0);
        data_bit(1'b0, 2'd0, "R3", 1'b0, 0, 0);
        wait_until(T + 2);
        run = 1'b0;
        push(T + 3, EV_SCL_RISE, "R10");
        if (!cur) push(T + 3, EV_SDA_RISE, "R10");
        wait_until(T + 3);
        check("R10", scl_o, 1, "scl after abort");
        check("R10", sda_o, 1, "sda after abort");
        check("R10", bus_free, 1, "bus_free after abort");
        cur = 1'b1;
        repeat (4) @(negedge clk);

        // transfer C: asymmetric counts set while idle
        set_div(5, 1);
        @(negedge clk);
        start_txn("R9");
        data_bit(1'b0, 2'd0, "R2", 1'b0, 0, 0);
        stop_txn();
        run = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", bus_free, 1, "idle at end");
        finish_up();
    end

endmodule